// File: doc/BRIEF.md
# Coprocessor Bus-Request and Reset Controller

This block sits on a host processor's byte bus and lets that host control a secondary processor. The host can pull the secondary processor off its bus and hold it in reset. The block decodes a 16 KB register window and drives two level outputs. One asks the secondary processor to release its bus. The other holds that processor in reset. A status register reads back the condition in which the host may safely use the shared bus: the bus has been requested and the secondary processor is held in reset at the same time.

The two control registers do not share a write polarity. A nonzero byte written to the bus-request register raises the request. For the reset register it is the other way round: a zero byte holds the secondary processor in reset, and a nonzero byte lets it run. The mode register accepts writes and has no effect. Any access the block does not decode produces a one-cycle diagnostic pulse.

The two outputs form a four-state machine. The states are `ST_RUN` (no request, not in reset), `ST_BUSHELD` (request only), `ST_HELDRST` (reset only) and `ST_PARKED` (both). `ST_HELDRST` is the power-on state. The transitions are:
- `T_TAKE`: `ST_RUN` to `ST_BUSHELD`.
- `T_HOLD`: `ST_RUN` to `ST_HELDRST`.
- `T_GIVE`: `ST_BUSHELD` to `ST_RUN`.
- `T_PARK_R`: `ST_BUSHELD` to `ST_PARKED`.
- `T_RELEASE`: `ST_HELDRST` to `ST_RUN`.
- `T_PARK_B`: `ST_HELDRST` to `ST_PARKED`.
- `T_UNPARK_B`: `ST_PARKED` to `ST_HELDRST`, when the request is dropped.
- `T_UNPARK_R`: `ST_PARKED` to `ST_BUSHELD`, when the reset is released.

Top module: `coproc_busctl`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first write, `cp_busreq` is 0, `cp_hold_reset` is 1, `host_rdata` is 0x00 and `bad_access` is 0.
- R2: A write to offset 0x100 with any nonzero byte sets `cp_busreq` to 1, and a write of 0x00 there clears it. The output changes on the clock edge that samples the write strobe.
- R3: A write to offset 0x200 with the byte 0x00 sets `cp_hold_reset` to 1, and any nonzero byte clears it. The output changes on the clock edge that samples the write strobe.
- R4: A read of offset 0x100 returns 0x01 on `host_rdata` one cycle after the read strobe if, in the strobe cycle, both `cp_busreq` and `cp_hold_reset` are 1. Otherwise it returns 0x00.
- R5: A write of any byte to offset 0x000 is accepted. It changes neither output and does not raise `bad_access`.
- R6: Writes to any offset other than 0x000, 0x100 and 0x200 change no output. Reads of any offset other than 0x100 return 0x00. Both kinds of access raise `bad_access` in the next cycle. Offsets are matched on all 14 address bits, so 0x3100 is undecoded.
- R7: A write to one control register leaves the other control output unchanged.
- R8: `bad_access` stays high for one cycle per undecoded access. Undecoded accesses in consecutive cycles give consecutive high cycles, and it is low after any decoded access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | 14 | Byte offset within the window |
| host_wdata | input | 8 | Write byte |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_rdata | output | 8 | Registered read data, valid one cycle after `host_rd` |
| cp_busreq | output | 1 | Bus request to the secondary processor |
| cp_hold_reset | output | 1 | Holds the secondary processor in reset when 1 |
| bad_access | output | 1 | One-cycle pulse for an undecoded access |

## Verification
The status read returns 0x01 only in `ST_PARKED`. Reaching that state takes two steps. The bus request has to be raised while reset is still asserted from power-on. Alternatively, reset has to be released and then re-asserted with a zero byte after the request has been raised. The directed tasks therefore take both routes in and both routes out of `ST_PARKED`, reading the status on each side. The back-to-back pulse case of `bad_access` needs strobes in adjacent cycles. A dedicated task keeps the strobe high across two edges with different undecoded offsets.

// File: rtl/coproc_busctl_pkg.sv
package coproc_busctl_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'b00,
        ST_BUSHELD = 2'b01,
        ST_HELDRST = 2'b10,
        ST_PARKED  = 2'b11
    } cp_state_e;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_REQ_ON  = 3'd1,
        CMD_REQ_OFF = 3'd2,
        CMD_RST_ON  = 3'd3,
        CMD_RST_OFF = 3'd4,
        CMD_MODE    = 3'd5
    } cp_cmd_e;

endpackage

// File: rtl/coproc_busctl_decode.sv
module coproc_busctl_decode
    import coproc_busctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] OFS_MODE = 'h000,
    parameter logic [ADDR_W-1:0] OFS_REQ  = 'h100,
    parameter logic [ADDR_W-1:0] OFS_RST  = 'h200
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    output cp_cmd_e           cmd,
    output logic              rd_status,
    output logic              bad
);

    logic hit_mode;
    logic hit_req;
    logic hit_rst;
    logic nonzero;

    always_comb begin
        hit_mode = (addr == OFS_MODE);
        hit_req  = (addr == OFS_REQ);
        hit_rst  = (addr == OFS_RST);
        nonzero  = |wdata;
    end

    // Write command: the two controls use opposite data polarity
    always_comb begin
        cmd = CMD_NONE;
        if (wr) begin
            if (hit_req) begin
                cmd = nonzero ? CMD_REQ_ON : CMD_REQ_OFF;
            end else if (hit_rst) begin
                cmd = nonzero ? CMD_RST_OFF : CMD_RST_ON;
            end else if (hit_mode) begin
                cmd = CMD_MODE;
            end
        end
    end

    always_comb begin
        rd_status = rd && hit_req;
        bad       = (wr && !(hit_req || hit_rst || hit_mode))
                 || (rd && !hit_req);
    end

endmodule

// File: rtl/coproc_busctl_fsm.sv
module coproc_busctl_fsm
    import coproc_busctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  cp_cmd_e cmd,
    output logic    busreq,
    output logic    hold_reset
);

    cp_state_e state_q;
    cp_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HELDRST;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                case (cmd)
                    CMD_REQ_ON: state_d = ST_BUSHELD;   // T_TAKE
                    CMD_RST_ON: state_d = ST_HELDRST;   // T_HOLD
                    default:    state_d = ST_RUN;
                endcase
            end
            ST_BUSHELD: begin
                case (cmd)
                    CMD_REQ_OFF: state_d = ST_RUN;      // T_GIVE
                    CMD_RST_ON:  state_d = ST_PARKED;   // T_PARK_R
                    default:     state_d = ST_BUSHELD;
                endcase
            end
            ST_HELDRST: begin
                case (cmd)
                    CMD_RST_OFF: state_d = ST_RUN;      // T_RELEASE
                    CMD_REQ_ON:  state_d = ST_PARKED;   // T_PARK_B
                    default:     state_d = ST_HELDRST;
                endcase
            end
            ST_PARKED: begin
                case (cmd)
                    CMD_REQ_OFF: state_d = ST_HELDRST;  // T_UNPARK_B
                    CMD_RST_OFF: state_d = ST_BUSHELD;  // T_UNPARK_R
                    default:     state_d = ST_PARKED;
                endcase
            end
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_RUN:     begin busreq = 1'b0; hold_reset = 1'b0; end
            ST_BUSHELD: begin busreq = 1'b1; hold_reset = 1'b0; end
            ST_HELDRST: begin busreq = 1'b0; hold_reset = 1'b1; end
            ST_PARKED:  begin busreq = 1'b1; hold_reset = 1'b1; end
        endcase
    end

    AST_REQ_CMD_KEEPS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REQ_ON || cmd == CMD_REQ_OFF) |=> $stable(hold_reset)); // R7
    AST_RST_CMD_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RST_ON || cmd == CMD_RST_OFF) |=> $stable(busreq)); // R7

endmodule

// File: rtl/coproc_busctl_readback.sv
module coproc_busctl_readback #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_status,
    input  logic              bad,
    input  logic              busreq,
    input  logic              hold_reset,
    output logic [DATA_W-1:0] rdata,
    output logic              bad_access
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata      <= '0;
            bad_access <= 1'b0;
        end else begin
            rdata      <= rd_status ? {{(DATA_W-1){1'b0}}, (busreq & hold_reset)} : '0;
            bad_access <= bad;
        end
    end

    AST_NO_STALE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !bad |=> !bad_access); // R8
    AST_FLAG_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> bad_access); // R6

endmodule

// File: rtl/coproc_busctl.sv
module coproc_busctl
    import coproc_busctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] OFS_MODE = 'h000,
    parameter logic [ADDR_W-1:0] OFS_REQ  = 'h100,
    parameter logic [ADDR_W-1:0] OFS_RST  = 'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              cp_busreq,
    output logic              cp_hold_reset,
    output logic              bad_access
);

    cp_cmd_e cmd;
    logic    rd_status;
    logic    bad;

    coproc_busctl_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .OFS_MODE(OFS_MODE),
        .OFS_REQ (OFS_REQ),
        .OFS_RST (OFS_RST)
    ) u_decode (
        .addr     (host_addr),
        .wdata    (host_wdata),
        .wr       (host_wr),
        .rd       (host_rd),
        .cmd      (cmd),
        .rd_status(rd_status),
        .bad      (bad)
    );

    coproc_busctl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .busreq    (cp_busreq),
        .hold_reset(cp_hold_reset)
    );

    coproc_busctl_readback #(
        .DATA_W(DATA_W)
    ) u_readback (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_status (rd_status),
        .bad       (bad),
        .busreq    (cp_busreq),
        .hold_reset(cp_hold_reset),
        .rdata     (host_rdata),
        .bad_access(bad_access)
    );

    AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_REQ && host_wdata != '0) |=> cp_busreq); // R2
    AST_REQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_REQ && host_wdata == '0) |=> !cp_busreq); // R2
    AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_RST && host_wdata == '0) |=> cp_hold_reset); // R3
    AST_RST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_RST && host_wdata != '0) |=> !cp_hold_reset); // R3
    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFS_REQ) |=>
            host_rdata == {{(DATA_W-1){1'b0}}, $past(cp_busreq && cp_hold_reset)}); // R4
    AST_OTHER_WRITES_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && (host_addr == OFS_REQ || host_addr == OFS_RST)) |=>
            $stable(cp_busreq) && $stable(cp_hold_reset)); // R5

endmodule

// File: tb/test_coproc_busctl.sv
module test_coproc_busctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic        cp_busreq;
    logic        cp_hold_reset;
    logic        bad_access;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    coproc_busctl i_coproc_busctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_wr      (host_wr),
        .host_rd      (host_rd),
        .host_rdata   (host_rdata),
        .cp_busreq    (cp_busreq),
        .cp_hold_reset(cp_hold_reset),
        .bad_access   (bad_access)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One write; returns the flag seen in the cycle after the strobe
    task automatic do_write(input logic [13:0] a, input logic [7:0] d, output logic flag);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        flag = bad_access;
    endtask

    task automatic do_read(input logic [13:0] a, output logic [7:0] data, output logic flag);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        data = host_rdata;
        flag = bad_access;
    endtask

    task automatic t_reset;
        chk("R1 busreq in reset", cp_busreq, 0);
        chk("R1 hold_reset in reset", cp_hold_reset, 1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busreq after reset", cp_busreq, 0);
        chk("R1 hold_reset after reset", cp_hold_reset, 1);
        chk("R1 rdata after reset", host_rdata, 0);
        chk("R1 bad_access after reset", bad_access, 0);
    endtask

    task automatic t_park_via_request;
        logic f; logic [7:0] r;
        do_read('h100, r, f);
        chk("R4 status reset only", r, 0);
        chk("R8 no flag on status read", f, 0);
        do_write('h100, 8'h5A, f);
        chk("R2 request on", cp_busreq, 1);
        chk("R7 reset kept", cp_hold_reset, 1);
        chk("R8 no flag on decoded write", f, 0);
        do_read('h100, r, f);
        chk("R4 status parked", r, 1);
        @(negedge clk);
        chk("R4 rdata cleared after read", host_rdata, 0);
        do_write('h100, 8'h00, f);
        chk("R2 request off", cp_busreq, 0);
        chk("R7 reset kept after drop", cp_hold_reset, 1);
    endtask

    task automatic t_reset_polarity;
        logic f; logic [7:0] r;
        do_write('h200, 8'h01, f);
        chk("R3 nonzero releases", cp_hold_reset, 0);
        chk("R7 request kept", cp_busreq, 0);
        do_write('h100, 8'hFF, f);
        chk("R2 request on while running", cp_busreq, 1);
        do_read('h100, r, f);
        chk("R4 status request only", r, 0);
        do_write('h200, 8'h00, f);
        chk("R3 zero holds", cp_hold_reset, 1);
        chk("R7 request kept on hold", cp_busreq, 1);
        do_read('h100, r, f);
        chk("R4 status parked second route", r, 1);
        do_write('h200, 8'h80, f);
        chk("R3 high bit releases", cp_hold_reset, 0);
        chk("R7 request kept on release", cp_busreq, 1);
    endtask

    task automatic t_mode;
        logic f;
        do_write('h000, 8'hFF, f);
        chk("R5 mode write busreq", cp_busreq, 1);
        chk("R5 mode write hold_reset", cp_hold_reset, 0);
        chk("R5 mode write not flagged", f, 0);
    endtask

    task automatic t_unhandled;
        logic f; logic [7:0] r;
        do_write('h101, 8'h00, f);
        chk("R6 write 0x101 flagged", f, 1);
        chk("R6 write 0x101 busreq", cp_busreq, 1);
        do_write('h3100, 8'h00, f);
        chk("R6 alias 0x3100 flagged", f, 1);
        chk("R6 alias 0x3100 busreq", cp_busreq, 1);
        do_write('h3200, 8'h00, f);
        chk("R6 alias 0x3200 hold_reset", cp_hold_reset, 0);
        @(negedge clk);
        chk("R8 flag drops", bad_access, 0);
        do_read('h200, r, f);
        chk("R6 read 0x200 data", r, 0);
        chk("R6 read 0x200 flagged", f, 1);
        do_read('h000, r, f);
        chk("R6 read 0x000 flagged", f, 1);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        host_addr = 'h300; host_wdata = 8'h00; host_wr = 1'b1;
        @(negedge clk);
        chk("R8 first pulse", bad_access, 1);
        host_addr = 'h1FFF;
        @(negedge clk);
        host_wr = 1'b0;
        chk("R8 second pulse", bad_access, 1);
        @(negedge clk);
        chk("R8 pulse ends", bad_access, 0);
        chk("R6 back-to-back busreq", cp_busreq, 1);
        chk("R6 back-to-back hold_reset", cp_hold_reset, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_park_via_request();
        t_reset_polarity();
        t_mode();
        t_unhandled();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule